// File: doc/BRIEF.md
# Buck Regulator Fault Sequencer

This block is the digital supervisor of a synchronous step-down regulator. Its inputs are five comparator flags:

- bias-supply good;
- probe pin above its threshold;
- feedback below its under-voltage trip;
- low-side over-current;
- external shutdown.

From these it decides when the power stage may switch. While it waits for the input rail, it sends short probe pulses on the high-side gate. It watches the probe pin for threshold crossings that show the rail is present. It then ramps a soft-start code that clamps the reference. Once running, it supervises the output and handles over-current and under-voltage through timed retries.

The controller is a five-state machine. The states are `ST_PROBE`, `ST_RAMP`, `ST_RUN`, `ST_BACKOFF` and `ST_LOCKOUT`, and the transitions are:

| Transition | Condition |
|---|---|
| `ST_PROBE` to `ST_RAMP` | four crossings have been counted |
| `ST_RAMP` to `ST_RUN` | the code reaches its top value |
| `ST_RUN` to `ST_BACKOFF` | an over-current, or a debounced under-voltage, with retries left |
| `ST_RUN` to `ST_LOCKOUT` | the fourth over-current |
| `ST_RUN` to `ST_PROBE` | the fourth under-voltage |
| `ST_BACKOFF` to `ST_RAMP` | one full soft-start interval has elapsed |
| any state to `ST_PROBE` | shutdown or loss of bias |

Every flag passes through a two-flop synchroniser before use. All timing is derived from the `CLK_KHZ` parameter:

| Quantity | Cycles |
|---|---|
| Probe period (`PER`) | `CLK_KHZ/10` |
| Probe high time (`ON`) | `PER/100`, at least 1 |
| Soft-start step (`STEP`) | `CLK_KHZ*3/256`, at least 1 |
| Under-voltage debounce (`UVC`) | `CLK_KHZ*15/1000`, at least 1 |

One soft-start interval is 256 steps.

Top module: `buck_fault_seq`

## Requirements
- R1: In `ST_PROBE`, with neither shutdown nor bias loss, `probe_gate` is high for exactly `ON` cycles in every `PER`-cycle period. `probe_gate` is never high together with `sw_en`.
- R2: In `ST_PROBE`, the block moves to `ST_RAMP` after the synchronised `ops_hi` has changed level four times, with rising and falling changes counted alike.
- R3: With fewer than four level changes on `ops_hi`, including `ops_hi` held high, `sw_en` stays 0 and probing continues.
- R4: In `ST_RAMP`, `ss_code` starts at 0 and rises by one every `STEP` cycles. `sw_en` goes to 1 when `ss_code` first leaves 0. `ss_code` goes from 1 to 255 in exactly 254*`STEP` cycles, and the block is in `ST_RUN` with `ss_code` = 255.
- R5: An under-voltage is acted on only after the synchronised `fb_uv` has been high for `UVC` consecutive cycles in `ST_RUN`. A shorter pulse has no effect.
- R6: Over-current and under-voltage trips in `ST_RUN` both share the back-off behaviour: `sw_en` = 0 and `ss_code` = 0 for 256*`STEP` cycles, then a fresh ramp, so `sw_en` is low for 257*`STEP` cycles. The fourth over-current since reset or shutdown instead enters `ST_LOCKOUT`, where `latched_off` = 1, `sw_en` = 0 and `ss_code` = 0, and it holds there.
- R7: `oc_trip` and `fb_uv` are ignored during `ST_RAMP`. They neither stop the ramp nor count as retries.
- R8: The fourth under-voltage trip returns the block to `ST_PROBE` (`latched_off` = 0, probing resumes) rather than locking out.
- R9: A synchronised `ext_dis` high forces `sw_en`, `probe_gate` and `latched_off` to 0 and returns the block to `ST_PROBE`. It also clears the crossing count and both retry counts.
- R10: While `rst_n` is low, or while the synchronised `por_ok` is low, all outputs are 0. When `por_ok` returns, the block restarts in `ST_PROBE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_KHZ` kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| ops_hi | input | 1 | Probe pin above its threshold |
| fb_uv | input | 1 | Feedback below its under-voltage level |
| oc_trip | input | 1 | Low-side over-current comparator |
| ext_dis | input | 1 | External shutdown request |
| probe_gate | output | 1 | Probe pulse train for the high-side gate |
| ss_code | output | CODE_W | Soft-start reference clamp code |
| sw_en | output | 1 | Power stage switching enable |
| latched_off | output | 1 | Over-current lockout status |

## Verification
The bench counts exact cycle spans against the values derived from `CLK_KHZ`:

- **Probe timing.** A prescaler off by one cycle would show as a wrong probe width or period.
- **Ramp length.** The same error would show as a ramp that is not exactly 254 steps.
- **Back-off length.** A back-off that dropped or added a step would not last 257 steps.

Under-voltage pulses of `UVC-3` cycles and held under-voltage are both applied. This catches a debounce that fires early or never clears.

A trip is injected in the middle of the ramp. A design that counted it would lock out on the third real over-current instead of the fourth.

Three crossings are followed by a long wait, to catch switching that starts too early. Shutdown is followed by a single over-current, to catch a retry count that survives shutdown. The fourth under-voltage is followed by a check for probe pulses, to catch a design that locks out on that path.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [2:0] {
        ST_PROBE   = 3'd0,
        ST_RAMP    = 3'd1,
        ST_RUN     = 3'd2,
        ST_BACKOFF = 3'd3,
        ST_LOCKOUT = 3'd4
    } seq_state_t;

endpackage

// File: rtl/bfs_flag_sync.sv
module bfs_flag_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic [1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= 2'b00;
                else        sh <= {sh[0], d[i]};
            end
            assign q[i] = sh[1];
        end
    endgenerate

endmodule

// File: rtl/bfs_probe_gen.sv
module bfs_probe_gen #(
    parameter int PERIOD = 100,
    parameter int ON     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pulse
);

    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HIGHN = CW'(ON);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign pulse = en && (cnt < HIGHN);

    // R1: the phase counter never passes the end of the period
    p_probe_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/bfs_edge_count.sv
module bfs_edge_count #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lvl,
    output logic done
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] TOP = CW'(N);

    logic          prev;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
        end else begin
            prev <= lvl;
            if (clr)                            cnt <= '0;
            else if ((lvl != prev) && (cnt != TOP)) cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == TOP);

    // R2: crossing count saturates at the required number
    p_cross_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
    // R2: once complete, the result holds until cleared
    p_cross_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

endmodule

// File: rtl/bfs_uv_filter.sv
module bfs_uv_filter #(
    parameter int CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic uv,
    output logic trip
);

    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en || !uv) cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign trip = (cnt == TOP);

    // R5: a trip implies the flag and the enable were both present last cycle
    p_uv_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> ($past(uv) && $past(en)));

endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
    import bfs_pkg::*;
#(
    parameter int CLK_KHZ   = 200000,
    parameter int SS_MS     = 3,
    parameter int UV_US     = 15,
    parameter int PROBE_KHZ = 10,
    parameter int PROBE_PCT = 1,
    parameter int CROSS_N   = 4,
    parameter int RETRY_MAX = 4,
    parameter int CODE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              ops_hi,
    input  logic              fb_uv,
    input  logic              oc_trip,
    input  logic              ext_dis,
    output logic              probe_gate,
    output logic [CODE_W-1:0] ss_code,
    output logic              sw_en,
    output logic              latched_off
);

    localparam int PROBE_PER = CLK_KHZ / PROBE_KHZ;
    localparam int PROBE_RAW = (PROBE_PER * PROBE_PCT) / 100;
    localparam int PROBE_ON  = (PROBE_RAW < 1) ? 1 : PROBE_RAW;
    localparam int STEPS     = 1 << CODE_W;
    localparam int STEP_RAW  = (CLK_KHZ * SS_MS) / STEPS;
    localparam int SS_STEP   = (STEP_RAW < 1) ? 1 : STEP_RAW;
    localparam int UV_RAW    = (CLK_KHZ * UV_US) / 1000;
    localparam int UV_CYC    = (UV_RAW < 1) ? 1 : UV_RAW;
    localparam int PW        = $clog2(SS_STEP + 1);
    localparam int RW        = $clog2(RETRY_MAX + 1);
    localparam logic [PW-1:0]     PRE_LAST = PW'(SS_STEP - 1);
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
    localparam logic [RW-1:0]     RET_LAST = RW'(RETRY_MAX - 1);

    // synchronised flags
    logic por_s, ops_s, uv_s, oc_s, dis_s;
    logic kill;

    bfs_flag_sync #(.W(5)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({por_ok, ops_hi, fb_uv, oc_trip, ext_dis}),
        .q     ({por_s, ops_s, uv_s, oc_s, dis_s})
    );

    assign kill = !por_s || dis_s;

    seq_state_t        state, nxt;
    logic [CODE_W-1:0] step_q;
    logic [PW-1:0]     pre_q;
    logic [RW-1:0]     oc_cnt, uv_cnt;
    logic              tick, vin_done, uv_trip, probe_en;

    assign tick = (pre_q == PRE_LAST);

    bfs_edge_count #(.N(CROSS_N)) cross_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state != ST_PROBE) || kill),
        .lvl   (ops_s),
        .done  (vin_done)
    );

    bfs_uv_filter #(.CYC(UV_CYC)) uvf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((state == ST_RUN) && !kill),
        .uv    (uv_s),
        .trip  (uv_trip)
    );

    bfs_probe_gen #(.PERIOD(PROBE_PER), .ON(PROBE_ON)) probe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (probe_en),
        .pulse (probe_gate)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PROBE:   if (vin_done) nxt = ST_RAMP;
            ST_RAMP:    if (tick && (step_q == CODE_TOP - 1'b1)) nxt = ST_RUN;
            ST_RUN: begin
                if (oc_s)
                    nxt = (oc_cnt == RET_LAST) ? ST_LOCKOUT : ST_BACKOFF;
                else if (uv_trip)
                    nxt = (uv_cnt == RET_LAST) ? ST_PROBE : ST_BACKOFF;
            end
            ST_BACKOFF: if (tick && (step_q == CODE_TOP)) nxt = ST_RAMP;
            ST_LOCKOUT: nxt = ST_LOCKOUT;
            default:    nxt = ST_PROBE;
        endcase
        if (kill) nxt = ST_PROBE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PROBE;
        else        state <= nxt;
    end

    // step timer, ramp code and retry counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            pre_q  <= '0;
            oc_cnt <= '0;
            uv_cnt <= '0;
        end else if (kill) begin
            step_q <= '0;
            pre_q  <= '0;
            oc_cnt <= '0;
            uv_cnt <= '0;
        end else begin
            if (nxt != state) begin
                pre_q  <= '0;
                step_q <= (nxt == ST_RUN) ? CODE_TOP : '0;
            end else if ((state == ST_RAMP) || (state == ST_BACKOFF)) begin
                if (tick) begin
                    pre_q  <= '0;
                    step_q <= step_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            if ((state == ST_RUN) && (nxt != ST_RUN)) begin
                if (oc_s)
                    oc_cnt <= oc_cnt + 1'b1;
                else if (uv_trip)
                    uv_cnt <= (uv_cnt == RET_LAST) ? '0 : uv_cnt + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        probe_en    = 1'b0;
        sw_en       = 1'b0;
        ss_code     = '0;
        latched_off = 1'b0;
        unique case (state)
            ST_PROBE:   probe_en = !kill;
            ST_RAMP: begin
                sw_en   = (step_q != '0) && !kill;
                ss_code = step_q;
            end
            ST_RUN: begin
                sw_en   = !kill;
                ss_code = step_q;
            end
            ST_BACKOFF: ;
            ST_LOCKOUT: latched_off = !kill;
            default: ;
        endcase
    end

    // R1: probe pulses and switching never overlap
    p_probe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        probe_gate |-> !sw_en);
    // R4: the ramp code moves by at most one step per cycle
    p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && $past(state) == ST_RAMP && !kill)
            |-> (ss_code == $past(ss_code) || ss_code == $past(ss_code) + 1'b1));
    // R7: faults cannot divert a ramp into back-off or lockout
    p_ramp_immune_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP) |=> (state != ST_BACKOFF && state != ST_LOCKOUT));
    // R6: lockout persists until shutdown or bias loss
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT && !kill) |=> (state == ST_LOCKOUT));
    // R8: the last permitted under-voltage goes back to probing
    p_uv_reprobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && uv_trip && !oc_s && uv_cnt == RET_LAST && !kill)
            |=> (state == ST_PROBE));
    // R9: shutdown clears state and both retry counts
    p_kill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (state == ST_PROBE && oc_cnt == '0 && uv_cnt == '0));

endmodule

// File: tb/buck_fault_seq_tb_top.sv
`timescale 1ns/1ps
module buck_fault_seq_tb_top;

    localparam int CLK_KHZ = 1000;
    localparam int PER  = CLK_KHZ / 10;
    localparam int ON   = (PER / 100 < 1) ? 1 : PER / 100;
    localparam int STEP = (CLK_KHZ * 3) / 256;
    localparam int UVC  = (CLK_KHZ * 15) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok = 1'b0, ops_hi = 1'b1, fb_uv = 1'b0, oc_trip = 1'b0, ext_dis = 1'b0;
    logic probe_gate, sw_en, latched_off;
    logic [7:0] ss_code;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    buck_fault_seq #(.CLK_KHZ(CLK_KHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ops_hi(ops_hi),
        .fb_uv(fb_uv), .oc_trip(oc_trip), .ext_dis(ext_dis),
        .probe_gate(probe_gate), .ss_code(ss_code), .sw_en(sw_en),
        .latched_off(latched_off)
    );

    typedef struct {
        string req;
        int    code;
        bit    en;
        bit    lat;
        bit    prb;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_exp(string req, int code, bit en, bit lat, bit prb);
        exp_t e;
        e.req = req; e.code = code; e.en = en; e.lat = lat; e.prb = prb;
        sbq.push_back(e);
    endtask

    // monitor side: compares while outputs are stable at a falling edge
    initial begin
        forever begin
            exp_t e;
            wait (sbq.size() != 0);
            e = sbq.pop_front();
            chk(int'(ss_code) == e.code, {e.req, " ss_code"}, ss_code, e.code);
            chk(sw_en == e.en,           {e.req, " sw_en"}, sw_en, e.en);
            chk(latched_off == e.lat,    {e.req, " latched_off"}, latched_off, e.lat);
            chk(probe_gate == e.prb,     {e.req, " probe_gate"}, probe_gate, e.prb);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_ops(int n);
        for (int i = 0; i < n; i++) begin
            ops_hi = ~ops_hi;
            cyc(10);
        end
    endtask

    task automatic wait_code(string req, int code, int limit);
        int n = 0;
        while (int'(ss_code) != code && n < limit) begin
            cyc(1);
            n++;
        end
        chk(int'(ss_code) == code, req, ss_code, code);
    endtask

    task automatic measure_probe(string req);
        int n = 0, hi = 0, per = 0;
        while (probe_gate !== 1'b1 && n < 3 * PER) begin cyc(1); n++; end
        chk(probe_gate === 1'b1, {req, " probe seen"}, probe_gate, 1);
        while (probe_gate === 1'b1 && hi < 3 * PER) begin cyc(1); hi++; per++; end
        while (probe_gate !== 1'b1 && per < 3 * PER) begin cyc(1); per++; end
        chk(hi == ON,   {req, " probe width"}, hi, ON);
        chk(per == PER, {req, " probe period"}, per, PER);
    endtask

    task automatic run_ramp_to_top();
        toggle_ops(4);
        wait_code("R2 ramp completes", 255, 300 * STEP);
    endtask

    initial begin
        int n, seen;
        // R10: reset state
        cyc(3);
        push_exp("R10 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(10);
        push_exp("R10 bias low", 0, 0, 0, 0);
        por_ok = 1'b1;
        cyc(5);

        // R1: probe train
        measure_probe("R1");

        // R3: flag held high, then three crossings only
        seen = 0;
        for (int i = 0; i < 1000; i++) begin cyc(1); if (sw_en) seen++; end
        chk(seen == 0, "R3 held high no switching", seen, 0);
        toggle_ops(3);
        seen = 0;
        for (int i = 0; i < 600; i++) begin cyc(1); if (sw_en) seen++; end
        chk(seen == 0, "R3 three crossings no switching", seen, 0);
        measure_probe("R3");

        // R2: fourth crossing starts the ramp
        toggle_ops(1);
        n = 0;
        while (int'(ss_code) != 1 && n < 4 * STEP) begin cyc(1); n++; end
        chk(int'(ss_code) == 1, "R2 ramp started", ss_code, 1);
        chk(sw_en == 1'b1, "R4 enable with first step", sw_en, 1);

        // R4 ramp length, R7 faults injected mid-ramp
        n = 0;
        while (int'(ss_code) != 255 && n < 300 * STEP) begin
            cyc(1); n++;
            if (n == 600)  begin oc_trip = 1'b1; fb_uv = 1'b1; end
            if (n == 606)  oc_trip = 1'b0;
            if (n == 660)  fb_uv = 1'b0;
        end
        chk(n == 254 * STEP, "R4 ramp length", n, 254 * STEP);
        push_exp("R7 ramp unaffected", 255, 1, 0, 0);
        cyc(20);

        // R5: short under-voltage ignored
        fb_uv = 1'b1; cyc(UVC - 3); fb_uv = 1'b0;
        cyc(40);
        push_exp("R5 short uv ignored", 255, 1, 0, 0);

        // R5 / R6: held under-voltage, first trip
        fb_uv = 1'b1;
        cyc(UVC + 1);
        push_exp("R5 before debounce", 255, 1, 0, 0);
        cyc(3);
        push_exp("R5 after debounce", 0, 0, 0, 0);
        fb_uv = 1'b0;
        wait_code("R6 restart after uv", 255, 600 * STEP);

        // R6 / R8: further under-voltage trips
        for (int k = 2; k <= 4; k++) begin
            fb_uv = 1'b1;
            n = 0;
            while (sw_en && n < 100) begin cyc(1); n++; end
            fb_uv = 1'b0;
            if (k < 4) begin
                n = 0;
                while (!sw_en && n < 300 * STEP) begin cyc(1); n++; end
                chk(n == 257 * STEP, "R6 backoff span", n, 257 * STEP);
                wait_code("R6 ramp after backoff", 255, 300 * STEP);
            end else begin
                push_exp("R8 no lockout", 0, 0, 0, probe_gate);
                measure_probe("R8");
            end
        end

        // over-current trips
        run_ramp_to_top();
        for (int k = 1; k <= 4; k++) begin
            oc_trip = 1'b1; cyc(2); oc_trip = 1'b0;
            cyc(6);
            push_exp("R6 oc trip", 0, 0, (k == 4), 0);
            if (k < 4) begin
                wait_code("R6 oc retry", 255, 600 * STEP);
                push_exp("R7 no early lockout", 255, 1, 0, 0);
                cyc(5);
            end
        end
        cyc(2000);
        push_exp("R6 lockout held", 0, 0, 1, 0);
        cyc(1);

        // R9: shutdown
        ext_dis = 1'b1;
        cyc(4);
        push_exp("R9 shutdown", 0, 0, 0, 0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin cyc(1); if (probe_gate) seen++; end
        chk(seen == 0, "R9 no probe while off", seen, 0);
        ext_dis = 1'b0;
        cyc(5);
        measure_probe("R9");
        run_ramp_to_top();
        oc_trip = 1'b1; cyc(2); oc_trip = 1'b0;
        cyc(6);
        push_exp("R9 retry count cleared", 0, 0, 0, 0);
        wait_code("R9 ramp again", 255, 600 * STEP);

        // R10: bias loss
        por_ok = 1'b0;
        cyc(4);
        push_exp("R10 bias lost", 0, 0, 0, 0);
        cyc(50);
        por_ok = 1'b1;
        cyc(5);
        measure_probe("R10");
        cyc(2);
        finish_run();
    end

endmodule